// File: doc/BRIEF.md
# Background Boundary Gap Estimator

This block removes the missing-code (or duplicated-code) step that a single bit decision of one pipeline stage leaves in a converter's raw output. It does this in the background, using only the data stream. Each raw code arrives qualified by a valid flag and tagged with that stage's decision bit. The block keeps two running extremes. One is the largest code seen with decision 0. The other is the smallest code seen with decision 1. The distance between them, less one, is taken as the size of the gap at the boundary.

Every sample on the upper side of the boundary has the current estimate subtracted from it, which closes the gap. Samples on the lower side pass through unchanged. An external strobe, pulsed at whatever interval the system chooses, clears both extremes so that the estimate can follow drift. The estimate keeps its last value until both sides have been seen again. The corrected stream may still carry an overall offset and gain error. Only the step at the boundary is removed.

Top module: `gap_cal_top`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows out_valid = 0, gap_est = 0 and out_code = 0.
- R2: out_valid equals in_valid delayed by exactly one clock; out_code changes only on a valid sample, one clock after it.
- R3: A valid sample with in_dec = 0 appears on out_code as its raw value, zero-extended.
- R4: A valid sample with in_dec = 1 appears on out_code as raw minus the gap_est value held before that sample's clock edge.
- R5: gap_est equals (smallest decision-1 code) − (largest decision-0 code) − 1 over the samples accepted since the last clear. It updates at the same edge that accepts a sample, so two adjacent codes give 0. A decision-0 code below the current maximum has no effect, and neither does a decision-1 code above the current minimum.
- R6: gap_est keeps its previous value until at least one valid sample of each decision has arrived since the last clear or reset.
- R7: A clear strobe discards both extremes, and gap_est holds through it. A valid sample in the same cycle as the strobe is the first sample of the new window.
- R8: gap_est is two's complement, CODE_W+1 bits wide, and is negative when the two sides overlap. out_code is two's complement, CODE_W+2 bits wide, so correction by a negative estimate raises the code.
- R9: A cycle with in_valid = 0 changes neither gap_est nor out_code, whatever in_code and in_dec hold.
- R10: Codes at the ends of the range are handled without wrap. Decision-0 code 2^CODE_W−1 and decision-1 code 0 give −2^CODE_W, and correction of code 0 by that estimate gives 2^CODE_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Qualifies in_code and in_dec |
| in_code | input | CODE_W | Raw unsigned converter code |
| in_dec | input | 1 | Decision bit of the calibrated stage |
| clear | input | 1 | Strobe that restarts the extreme-tracking window |
| out_valid | output | 1 | Qualifies out_code, one clock after in_valid |
| out_code | output | CODE_W+2 | Corrected code, two's complement |
| gap_est | output | CODE_W+1 | Current gap estimate, two's complement |

## Verification
The assertions take for granted that in_dec is consistent with the code it tags. A decision-0 code could exceed a decision-1 code only in the overlap that redundancy permits, and the properties on the extremes hold for either case. They also assume that clear and in_valid are held for whole cycles. The stimulus changes inputs only on the falling edge and applies clear on its own and together with a valid sample. Each input sequence is built so that the lower and upper windows are filled in a known order. This makes every expected estimate follow from the requirements alone.

// File: rtl/gap_cal_pkg.sv
// Shared types for the boundary gap calibration block.
// Assumes nothing beyond a single clock domain.
package gap_cal_pkg;
    // Which extreme a tracker keeps
    typedef enum logic {
        TRACK_MAX = 1'b0,
        TRACK_MIN = 1'b1
    } track_dir_e;
endpackage

// File: rtl/extreme_tracker.sv
// Keeps the running maximum or minimum of the codes presented with take=1.
// A clear restarts the window; a take in the same cycle seeds the new window.
// Also exposes next-state values so a consumer can act in the same edge.
// Assumes take is already qualified by valid and by the decision side.
module extreme_tracker
    import gap_cal_pkg::*;
#(
    parameter int         CODE_W = 12,
    parameter track_dir_e DIR    = TRACK_MAX
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] ext_q,
    output logic              seen_q,
    output logic [CODE_W-1:0] ext_nxt,
    output logic              seen_nxt
);
    localparam logic [CODE_W-1:0] INIT_VAL = (DIR == TRACK_MAX) ? '0 : '1;

    logic [CODE_W-1:0] base_val;
    logic              base_seen;
    logic              beats;

    // Start from a fresh window when cleared, else from the held extreme
    always_comb begin
        base_val  = clear ? INIT_VAL : ext_q;
        base_seen = clear ? 1'b0 : seen_q;
    end

    // Direction-specific comparison chosen at elaboration
    generate
        if (DIR == TRACK_MAX) begin : g_max
            assign beats = (code > base_val);
        end else begin : g_min
            assign beats = (code < base_val);
        end
    endgenerate

    // Next extreme and seen flag
    always_comb begin
        ext_nxt  = (take && (beats || !base_seen)) ? code : base_val;
        seen_nxt = base_seen | take;
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ext_q  <= INIT_VAL;
            seen_q <= 1'b0;
        end else begin
            ext_q  <= ext_nxt;
            seen_q <= seen_nxt;
        end
    end
endmodule

// File: rtl/gap_former.sv
// Forms the signed gap estimate min_upper - max_lower - 1 from the trackers'
// next-state values and holds it until both sides have samples.
// Assumes the inputs are the values the trackers load at this edge.
module gap_former #(
    parameter int CODE_W = 12,
    localparam int GAP_W = CODE_W + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CODE_W-1:0]       max_lo,
    input  logic [CODE_W-1:0]       min_hi,
    input  logic                    both_seen,
    output logic signed [GAP_W-1:0] gap_q
);
    logic signed [GAP_W-1:0] diff;

    // Difference fits GAP_W bits: range is -2^CODE_W .. 2^CODE_W-2
    always_comb begin
        diff = $signed({1'b0, min_hi}) - $signed({1'b0, max_lo})
             - $signed(GAP_W'(1));
    end

    // Load only when both windows are populated, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (both_seen) begin
            gap_q <= diff;
        end
    end
endmodule

// File: rtl/gap_corrector.sv
// Subtracts the held gap estimate from upper-side samples and registers the
// result with its valid flag. Lower-side samples pass zero-extended.
// Assumes gap is the estimate as it stood before this sample.
module gap_corrector #(
    parameter int CODE_W = 12,
    localparam int GAP_W = CODE_W + 1,
    localparam int OUT_W = CODE_W + 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [CODE_W-1:0]       in_code,
    input  logic                    in_dec,
    input  logic signed [GAP_W-1:0] gap,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_code
);
    logic signed [OUT_W-1:0] raw_x;
    logic signed [OUT_W-1:0] gap_x;
    logic signed [OUT_W-1:0] fixed;

    // Widen both operands and pick the corrected or raw value
    always_comb begin
        raw_x = $signed({2'b00, in_code});
        gap_x = OUT_W'(gap);
        fixed = in_dec ? (raw_x - gap_x) : raw_x;
    end

    // Output register, code held between valid samples
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_code  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_code <= fixed;
            end
        end
    end
endmodule

// File: rtl/gap_cal_top.sv
// Background gap estimator and corrector for one decision boundary.
// Lower-side samples feed a maximum tracker, upper-side samples a minimum
// tracker; the estimate is their distance less one. Upper samples are
// corrected with the estimate held before them. Assumes clear is a strobe
// produced elsewhere at the chosen adaptation interval.
module gap_cal_top
    import gap_cal_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [CODE_W-1:0]         in_code,
    input  logic                      in_dec,
    input  logic                      clear,
    output logic                      out_valid,
    output logic signed [CODE_W+1:0]  out_code,
    output logic signed [CODE_W:0]    gap_est
);
    logic              take_lo;
    logic              take_hi;
    logic [CODE_W-1:0] max_q;
    logic [CODE_W-1:0] min_q;
    logic [CODE_W-1:0] max_nxt;
    logic [CODE_W-1:0] min_nxt;
    logic              seen_lo_q;
    logic              seen_hi_q;
    logic              seen_lo_nxt;
    logic              seen_hi_nxt;

    // Route each valid sample to its side of the boundary
    always_comb begin
        take_lo = in_valid && !in_dec;
        take_hi = in_valid &&  in_dec;
    end

    extreme_tracker #(.CODE_W(CODE_W), .DIR(TRACK_MAX)) u_lo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .take     (take_lo),
        .code     (in_code),
        .ext_q    (max_q),
        .seen_q   (seen_lo_q),
        .ext_nxt  (max_nxt),
        .seen_nxt (seen_lo_nxt)
    );

    extreme_tracker #(.CODE_W(CODE_W), .DIR(TRACK_MIN)) u_hi (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .take     (take_hi),
        .code     (in_code),
        .ext_q    (min_q),
        .seen_q   (seen_hi_q),
        .ext_nxt  (min_nxt),
        .seen_nxt (seen_hi_nxt)
    );

    gap_former #(.CODE_W(CODE_W)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .max_lo    (max_nxt),
        .min_hi    (min_nxt),
        .both_seen (seen_lo_nxt && seen_hi_nxt),
        .gap_q     (gap_est)
    );

    gap_corrector #(.CODE_W(CODE_W)) u_cor (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_code   (in_code),
        .in_dec    (in_dec),
        .gap       (gap_est),
        .out_valid (out_valid),
        .out_code  (out_code)
    );
endmodule

// File: rtl/gap_cal_chk.sv
// Property checker for gap_cal_top, attached by bind below.
module gap_cal_chk #(
    parameter int CODE_W = 12
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     in_valid,
    input logic [CODE_W-1:0]        in_code,
    input logic                     in_dec,
    input logic                     clear,
    input logic                     out_valid,
    input logic signed [CODE_W+1:0] out_code,
    input logic signed [CODE_W:0]   gap_est,
    input logic [CODE_W-1:0]        max_q,
    input logic [CODE_W-1:0]        min_q
);
    logic signed [CODE_W+1:0] raw_w;
    logic signed [CODE_W+1:0] gap_w;
    assign raw_w = $signed({2'b00, in_code});
    assign gap_w = (CODE_W+2)'(gap_est);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && gap_est == '0 && out_code == '0));

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    lower_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dec) |=> out_code == $past(raw_w));

    // R4
    upper_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dec) |=> out_code == ($past(raw_w) - $past(gap_w)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(gap_est) && $stable(out_code)));

    // R5
    max_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_dec && !clear) |=> max_q >= $past(in_code));

    // R5
    min_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_dec && !clear) |=> min_q <= $past(in_code));
endmodule

bind gap_cal_top gap_cal_chk #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_code   (in_code),
    .in_dec    (in_dec),
    .clear     (clear),
    .out_valid (out_valid),
    .out_code  (out_code),
    .gap_est   (gap_est),
    .max_q     (max_q),
    .min_q     (min_q)
);

// File: tb/sim_gap_cal_top.sv
module sim_gap_cal_top;
    localparam int W = 12;

    typedef struct packed {
        logic                clr;
        logic                vld;
        logic                dec;
        logic [W-1:0]        code;
        logic signed [W:0]   est;
        logic signed [W+1:0] out;
    } vec_t;

    // Expected values worked out from R3..R9
    localparam int NV = 14;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 1'b0, 12'd100,  13'sd0,   14'sd100},  // R3 R6 one side only
        '{1'b0, 1'b1, 1'b1, 12'd130,  13'sd29,  14'sd130},  // R4 R5 first estimate
        '{1'b0, 1'b1, 1'b0, 12'd90,   13'sd29,  14'sd90},   // R5 lower max kept
        '{1'b0, 1'b1, 1'b1, 12'd140,  13'sd29,  14'sd111},  // R4 R5 upper min kept
        '{1'b0, 1'b1, 1'b0, 12'd110,  13'sd19,  14'sd110},  // R5 new max
        '{1'b0, 1'b1, 1'b1, 12'd120,  13'sd9,   14'sd101},  // R4 R5 new min
        '{1'b0, 1'b0, 1'b0, 12'd2000, 13'sd9,   14'sd101},  // R9 invalid ignored
        '{1'b0, 1'b1, 1'b1, 12'd111,  13'sd0,   14'sd102},  // R5 adjacent codes
        '{1'b1, 1'b0, 1'b0, 12'd0,    13'sd0,   14'sd102},  // R7 clear alone
        '{1'b0, 1'b1, 1'b1, 12'd200,  13'sd0,   14'sd200},  // R6 R7 upper only
        '{1'b0, 1'b1, 1'b0, 12'd210,  -13'sd11, 14'sd210},  // R8 overlap
        '{1'b0, 1'b1, 1'b1, 12'd205,  -13'sd11, 14'sd216},  // R8 negative correction
        '{1'b1, 1'b1, 1'b0, 12'd50,   -13'sd11, 14'sd50},   // R7 clear with sample
        '{1'b0, 1'b1, 1'b1, 12'd60,   13'sd9,   14'sd71}    // R7 new window
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [W-1:0]        in_code = '0;
    logic                in_dec = 1'b0;
    logic                clear = 1'b0;
    logic                out_valid;
    logic signed [W+1:0] out_code;
    logic signed [W:0]   gap_est;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gap_cal_top #(.CODE_W(W)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_code   (in_code),
        .in_dec    (in_dec),
        .clear     (clear),
        .out_valid (out_valid),
        .out_code  (out_code),
        .gap_est   (gap_est)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge; results are read one falling edge later
    task automatic step(input logic c, input logic v, input logic d,
                        input logic [W-1:0] code);
        clear    = c;
        in_valid = v;
        in_dec   = d;
        in_code  = code;
        @(negedge clk);
        clear    = 1'b0;
        in_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "out_valid", longint'(out_valid), 0);
        check("R1", "gap_est", longint'(gap_est), 0);
        check("R1", "out_code", longint'(out_code), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            step(TBL[i].clr, TBL[i].vld, TBL[i].dec, TBL[i].code);
            check("R2", $sformatf("vec%0d out_valid", i), longint'(out_valid), longint'(TBL[i].vld));
            check("R5", $sformatf("vec%0d gap_est", i), longint'(gap_est), longint'(TBL[i].est));
            check("R4", $sformatf("vec%0d out_code", i), longint'(out_code), longint'(TBL[i].out));
        end

        // R10 extreme overlap: lower at full scale, upper at zero
        step(1'b1, 1'b1, 1'b0, 12'd4095);
        step(1'b0, 1'b1, 1'b1, 12'd0);
        check("R10", "most negative gap", longint'(gap_est), -4096);
        step(1'b0, 1'b1, 1'b1, 12'd0);
        check("R10", "code 0 raised", longint'(out_code), 4096);
        check("R8", "sign kept", longint'(out_code[W+1]), 0);

        // R10 widest gap: lower at zero, upper at full scale
        step(1'b1, 1'b1, 1'b0, 12'd0);
        step(1'b0, 1'b1, 1'b1, 12'd4095);
        check("R10", "largest gap", longint'(gap_est), 4094);
        step(1'b0, 1'b1, 1'b1, 12'd4095);
        check("R10", "full scale corrected", longint'(out_code), 1);

        // R9 invalid upper sample after clear leaves estimate and output
        step(1'b0, 1'b0, 1'b1, 12'd7);
        check("R9", "gap_est held", longint'(gap_est), 4094);
        check("R9", "out_code held", longint'(out_code), 1);

        // R1 reset during operation
        rst_n = 1'b0;
        step(1'b0, 1'b1, 1'b1, 12'd300);
        check("R1", "gap_est after reset", longint'(gap_est), 0);
        check("R1", "out_valid after reset", longint'(out_valid), 0);
        rst_n = 1'b1;

        // R6 after reset one lower sample keeps estimate at 0
        step(1'b0, 1'b1, 1'b0, 12'd500);
        check("R6", "held after reset", longint'(gap_est), 0);
        step(1'b0, 1'b1, 1'b1, 12'd501);
        check("R5", "adjacent after reset", longint'(gap_est), 0);

        done = 1'b1;
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule